// File: doc/BRIEF.md
# APB Down-Counting Interval Timer

This block is a 32-bit interval timer reached through an APB slave port with a 4 KB address window. It has one level-sensitive interrupt output. Software sets a reload value and an enable bit. The counter then steps down by one on every clock. When it reaches zero it stays at zero for one clock, then takes the reload value again, so each period lasts the reload value plus one clocks. When interrupts are enabled, a decrement that lands on zero sets a sticky status flag. That flag drives the interrupt line until software clears it by writing a one.

A reload value of zero makes the timer a one-shot: the counter stops at zero until a nonzero reload value or a new count is written. Two control bits select an external clock and an external enable. They are stored and read back but have no effect. The top of the window holds twelve read-only identification words. The port never inserts wait states and never signals an error.

Top module: `apb_itimer`

## Requirements
- R1: The port follows the two-phase APB protocol. A write takes effect at the clock edge that ends its access phase. Read data is valid during the access phase. `pready` is always 1 and `pslverr` is always 0.
- R2: The control register sits at offset 0x000 and stores only write data bits [3:0]. Bit 0 is the enable and bit 3 is the interrupt enable. Bit 1 (external enable select) and bit 2 (external clock select) are stored but do not change counting. A read returns the four stored bits with all upper bits zero.
- R3: While the enable is 1, the count at offset 0x004 falls by exactly one per clock. Clearing the enable freezes the count. Setting it again resumes counting from the frozen value.
- R4: When the count is zero, the enable is 1 and the reload register at offset 0x008 is nonzero, the next clock loads the reload value. A free-running period is therefore reload+1 clocks.
- R5: Status bit 0 at offset 0x00C is set only when an enabled decrement takes the count from 1 to 0 while control bit 3 is 1. Writing zero into the count never sets it. The interrupt output always equals status bit 0.
- R6: A write to offset 0x00C with data bit 0 set clears status bit 0. Other data bits have no effect. If a decrement to zero lands in the same clock as the clearing write, the flag stays set.
- R7: With a reload value of zero the count stays at zero. Writing a nonzero reload value while enabled restarts counting on the next clock.
- R8: A write to offset 0x004 loads the count at that edge, overriding the decrement. Loading zero while the reload value is zero leaves the timer stopped.
- R9: Offsets 0xFD0 to 0xFFC hold twelve read-only words, in ascending address order: 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R10: Reads from any other offset, including unaligned ones, return zero. Writes there are ignored.
- R11: Synchronous reset clears the control, reload, status and count registers, so the timer is stopped and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 for write |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The embedded assertions check the counter's step rules on every cycle: one step down while enabled, frozen while disabled, reload from zero, stopped at zero with a zero reload, and a write overriding the step. They also check that the status flag rises only on an enabled decrement to zero, that a clearing write drops it, and that a coincident decrement wins over the clear. Only the bench scenarios can show the end-to-end behaviour: the exact interrupt latency after a count write, the measured reload+1 period, the register map contents and masking, ignored writes to the identification words and unmapped offsets, and the inert external-select bits.

// File: rtl/apb_itimer_pkg.sv
package apb_itimer_pkg;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_COUNT  = 12'h004;
  localparam logic [11:0] OFS_RELOAD = 12'h008;
  localparam logic [11:0] OFS_STATUS = 12'h00C;

  localparam int ID_WORDS = 12;
  localparam int CTRL_BITS = 4;

  // Control register layout, bit 3 down to bit 0
  typedef struct packed {
    logic irq_en;
    logic ext_clk_sel;
    logic ext_gate_sel;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input int idx);
    case (idx)
      0:  return 8'h04;
      4:  return 8'h22;
      5:  return 8'hB8;
      6:  return 8'h1B;
      8:  return 8'h0D;
      9:  return 8'hF0;
      10: return 8'h05;
      11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/apb_itimer_counter.sv
module apb_itimer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             step;

  always_comb begin
    at_zero = (cnt_q == '0);
    step    = run_i && !load_i;
    hit_o   = step && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i) begin
      if (!at_zero)
        cnt_q <= cnt_q - CNT_W'(1);
      else if (reload_i != '0)
        cnt_q <= reload_i;
    end
  end

  assign cnt_o = cnt_q;

  // R3: one step per clock while enabled
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R3: disabled count is frozen
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> (cnt_q == $past(cnt_q)));

  // R4: zero held one clock, then reload
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && cnt_q == '0 && reload_i != '0) |=> (cnt_q == $past(reload_i)));

  // R7: zero reload keeps the counter stopped
  a_r7_zero_stop: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && cnt_q == '0 && reload_i == '0) |=> (cnt_q == '0));

  // R8: a register write overrides the step
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/apb_itimer_idrom.sv
module apb_itimer_idrom
  import apb_itimer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int BASE_INT = (1 << ADDR_W) - 4 * ID_WORDS;
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(BASE_INT);

  logic [ID_WORDS-1:0] match;
  logic [DATA_W-1:0]   word [ID_WORDS];

  for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
    assign match[g] = (addr_i == ID_BASE + ADDR_W'(4 * g));
    assign word[g]  = match[g] ? DATA_W'(id_byte(g)) : '0;
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < ID_WORDS; i++)
      data_o = data_o | word[i];
    hit_o = |match;
  end

endmodule

// File: rtl/apb_itimer_regs.sv
module apb_itimer_regs
  import apb_itimer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              hit_i,
  input  logic              id_hit_i,
  input  logic [DATA_W-1:0] id_data_i,
  output logic [DATA_W-1:0] prdata_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              irq_o
);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic              flag_q;
  logic [DATA_W-1:0] prdata_q;

  logic wr_acc, rd_setup;
  logic at_ctrl, at_count, at_reload, at_status;
  logic set_flag, clr_flag;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    wr_acc    = psel && penable && pwrite;
    rd_setup  = psel && !penable && !pwrite;
    at_ctrl   = at_ofs(paddr, OFS_CTRL);
    at_count  = at_ofs(paddr, OFS_COUNT);
    at_reload = at_ofs(paddr, OFS_RELOAD);
    at_status = at_ofs(paddr, OFS_STATUS);
    set_flag  = hit_i && ctrl_q.irq_en;
    clr_flag  = wr_acc && at_status && pwdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_acc && at_ctrl)
        ctrl_q <= ctrl_t'(pwdata[CTRL_BITS-1:0]);
      if (wr_acc && at_reload)
        reload_q <= pwdata;
      if (set_flag)
        flag_q <= 1'b1;
      else if (clr_flag)
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (at_ctrl)        rd_mux = DATA_W'(ctrl_q);
    else if (at_count)  rd_mux = cnt_i;
    else if (at_reload) rd_mux = reload_q;
    else if (at_status) rd_mux = DATA_W'(flag_q);
    else if (id_hit_i)  rd_mux = id_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      prdata_q <= '0;
    else if (rd_setup)
      prdata_q <= rd_mux;
  end

  assign prdata_o   = prdata_q;
  assign ctrl_o     = ctrl_q;
  assign reload_o   = reload_q;
  assign load_o     = wr_acc && at_count;
  assign load_val_o = pwdata;
  assign irq_o      = flag_q;

  // R5: the flag rises only after an enabled decrement to zero
  a_r5_rise_on_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hit_i && ctrl_q.irq_en));

  // R6: a coincident hit keeps the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hit_i && ctrl_q.irq_en) |=> irq_o);

  // R6: a one in data bit 0 clears the flag
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && at_status && pwdata[0] && !(hit_i && ctrl_q.irq_en)) |=> !irq_o);

  // R2: control writes keep only the low bits
  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && at_ctrl) |=> (ctrl_o == $past(pwdata[CTRL_BITS-1:0])));

endmodule

// File: rtl/apb_itimer.sv
module apb_itimer
  import apb_itimer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, cnt, load_val, id_data;
  logic              load, hit, id_hit;

  apb_itimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata),
    .cnt_i(cnt), .hit_i(hit),
    .id_hit_i(id_hit), .id_data_i(id_data),
    .prdata_o(prdata), .ctrl_o(ctrl), .reload_o(reload),
    .load_o(load), .load_val_o(load_val), .irq_o(irq)
  );

  apb_itimer_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst),
    .run_i(ctrl.run), .load_i(load), .load_val_i(load_val),
    .reload_i(reload), .cnt_o(cnt), .hit_o(hit)
  );

  apb_itimer_idrom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_id (
    .addr_i(paddr), .hit_o(id_hit), .data_o(id_data)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // R11: reset leaves the interrupt low and the counter stopped
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (!irq && cnt == '0));

endmodule

// File: tb/apb_itimer_tb_top.sv
module apb_itimer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int wr_cyc = 0;
  bit done = 0;

  apb_itimer dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {is_write, addr, data, expected read}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'hFD0, 32'h0, 32'h04},  // R9
    {1'b0, 12'hFD4, 32'h0, 32'h00},
    {1'b0, 12'hFD8, 32'h0, 32'h00},
    {1'b0, 12'hFDC, 32'h0, 32'h00},
    {1'b0, 12'hFE0, 32'h0, 32'h22},
    {1'b0, 12'hFE4, 32'h0, 32'hB8},
    {1'b0, 12'hFE8, 32'h0, 32'h1B},
    {1'b0, 12'hFEC, 32'h0, 32'h00},
    {1'b0, 12'hFF0, 32'h0, 32'h0D},
    {1'b0, 12'hFF4, 32'h0, 32'hF0},
    {1'b0, 12'hFF8, 32'h0, 32'h05},
    {1'b0, 12'hFFC, 32'h0, 32'hB1},
    {1'b1, 12'hFE0, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'hFE0, 32'h0, 32'h22},  // R9 write ignored
    {1'b1, 12'h014, 32'h1234_5678, 32'h0},
    {1'b0, 12'h014, 32'h0, 32'h0},   // R10
    {1'b0, 12'h802, 32'h0, 32'h0},   // R10 unaligned
    {1'b1, 12'h000, 32'hFFFF_FFF6, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h6},   // R2
    {1'b1, 12'h008, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 12'h008, 32'h0, 32'hDEAD_BEEF},
    {1'b0, 12'h004, 32'h0, 32'h0}    // R2 ext bits do not run it
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_irq(input int lim, output bit ok);
    int n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
    ok = irq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, a, b, c, d;
    bit ok;
    int t0, t1;

    repeat (3) @(negedge clk);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    chk("R1 pready", {31'b0, pready}, 32'h1);
    chk("R1 pslverr", {31'b0, pslverr}, 32'h0);
    rst = 0;
    @(negedge clk);
    rd(12'h000, v); chk("R11 ctrl", v, 0);
    rd(12'h004, v); chk("R11 count", v, 0);
    rd(12'h008, v); chk("R11 reload", v, 0);
    rd(12'h00C, v); chk("R11 status", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], v);
        chk($sformatf("R1/R2/R9/R10 vec %0d", i), v, VEC[i][31:0]);
      end
    end

    // R5 latency: count 4, irq after four decrements
    wr(12'h008, 0);
    wr(12'h000, 32'h9);
    wr(12'h004, 4);
    t0 = wr_cyc;
    wait_irq(20, ok);
    chk("R5 irq rose", {31'b0, ok}, 1);
    chk("R5 latency", cyc - t0, 4);
    rd(12'h004, v); chk("R7 stopped at zero", v, 0);
    wr(12'h00C, 1);
    chk("R6 clear", {31'b0, irq}, 0);

    // R4/R7 period with reload 7
    wr(12'h008, 7);
    wait_irq(30, ok);
    chk("R7 resume after reload", {31'b0, ok}, 1);
    t1 = cyc;
    wr(12'h00C, 1);
    wait_irq(30, ok);
    chk("R4 period", cyc - t1, 8);

    // R3 rate, freeze and resume
    wr(12'h008, 0);
    wr(12'h004, 1000);
    wr(12'h00C, 1);
    chk("R6 clear again", {31'b0, irq}, 0);
    rd(12'h004, a); rd(12'h004, b);
    chk("R3 two steps", b, a - 2);
    wr(12'h000, 32'h8);
    rd(12'h004, a); repeat (5) @(negedge clk); rd(12'h004, b);
    chk("R3 frozen", b, a);
    wr(12'h000, 32'h6);
    rd(12'h004, c); repeat (5) @(negedge clk); rd(12'h004, d);
    chk("R2 select bits inert", d, c);
    chk("R2 select bits keep value", c, a);
    wr(12'h000, 32'h9);
    rd(12'h004, a); rd(12'h004, b);
    chk("R3 resumed", b, a - 2);
    chk("R3 resumed from frozen", {31'b0, (a <= c && a > c - 4)}, 1);

    // R8 loads
    wr(12'h004, 0);
    repeat (10) @(negedge clk);
    chk("R5 zero load no irq", {31'b0, irq}, 0);
    rd(12'h004, v); chk("R8 zero load stays stopped", v, 0);
    wr(12'h004, 50);
    rd(12'h004, v); chk("R8 immediate load", v, 50);

    // R6 coincident set and clear, ignored bits
    wr(12'h004, 2);
    wr(12'h00C, 1);
    chk("R6 set wins", {31'b0, irq}, 1);
    wr(12'h00C, 32'hFFFF_FFFE);
    chk("R6 other bits ignored", {31'b0, irq}, 1);
    rd(12'h00C, v); chk("R5 status equals irq", v, 1);
    wr(12'h00C, 1);
    chk("R6 final clear", {31'b0, irq}, 0);

    // R5 interrupt enable off
    wr(12'h000, 32'h1);
    wr(12'h004, 3);
    repeat (10) @(negedge clk);
    chk("R5 no irq when disabled", {31'b0, irq}, 0);
    rd(12'h004, v); chk("R5 count reached zero", v, 0);

    // R11 reset mid-run
    wr(12'h000, 32'h9);
    wr(12'h008, 5);
    wr(12'h004, 100);
    rst = 1;
    @(negedge clk);
    rst = 0;
    rd(12'h000, v); chk("R11 ctrl after run", v, 0);
    rd(12'h008, v); chk("R11 reload after run", v, 0);
    rd(12'h004, v); chk("R11 count after run", v, 0);
    chk("R11 irq after run", {31'b0, irq}, 0);

    finish_run();
  end

endmodule